// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits between a clock source and a group of clock output lanes that all run from the same source clock. It passes the source clock to each lane or holds the lane low. The reason for holding a lane low can be a stop request, a power-down request, or a per-lane enable bit. The stop and power-down requests may arrive with no timing relation to the clock, so both go through a multi-flop synchronizer before they take effect. Every lane decision is captured by a level-sensitive latch that is open only while the source clock is low. A lane therefore changes state only between pulses. It never shows a truncated high phase, and it always parks at logic 0.

Lanes come in three kinds, chosen at elaboration time. Ordinary lanes obey the stop request. Fixed free lanes ignore it. Selectable lanes follow a select input: a 0 on the select makes them free-running and a 1 makes them stoppable. Every lane obeys its own enable bit, and every lane obeys power-down. The block produces no clock of its own.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every lane of `clk_out` is 0. After release, the synchronizer starts from the state "stop requested and powered down". With SYNC_STAGES = 2, the first pulse can appear no earlier than the third rising edge after release.
- R2: A lane is never high while `clk` is low. Every lane that is held off stays at logic 0.
- R3: A lane changes between gated and passing only while `clk` is low. Every pulse it emits spans the whole high phase of `clk`, even when `out_en` or `sel_stoppable` changes during that high phase.
- R4: Let the levels of `stop_n` and `pwr_down` be sampled at rising edge k. Those samples govern the pulse that starts at rising edge k+SYNC_STAGES. With the default of 2 stages, after a sampled request change exactly two further pulses are unaffected, and the change then applies. This holds for stopping (stop_n = 0) and for restarting (stop_n = 1) alike, so both latencies are below 4 clocks.
- R5: Lanes whose bit is set in FREE_MASK keep running while stop_n is 0. Lanes that are not stoppable are never disturbed by the stop request. In the default configuration, lane 3 is a fixed free lane.
- R6: Lanes whose bit is set in SEL_MASK (by default lane 2) follow `sel_stoppable`. A 0 makes them free-running and a 1 makes them stoppable. The value in force during the low phase before a rising edge governs the pulse of that edge.
- R7: `out_en[i]` = 0 holds lane i low and stops it from switching. The value present at a rising edge governs the pulse of that edge. An enable of 1 lets the lane run, subject to the other controls.
- R8: Power-down (`pwr_down` = 1) uses the same synchronizer and latency as R4. It forces every lane low, including free and selectable lanes, whatever the state of `stop_n`, `out_en` and `sel_stoppable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock shared by all lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request for stoppable lanes |
| pwr_down | input | 1 | Asynchronous active-high request that forces all lanes low |
| sel_stoppable | input | 1 | For SEL_MASK lanes: 0 = free-running, 1 = stoppable |
| out_en | input | N | Per-lane enable, 1 = lane may run (reset default of the driving register is all ones) |
| clk_out | output | N | Gated lane clocks |

## Verification
The clocked properties assume that `out_en` and `sel_stoppable` change only while `clk` is high. Under that condition, the value sampled at a rising edge is the one the latch saw during the preceding low phase. They also assume that reset is released while `clk` is low. `stop_n` and `pwr_down` carry no such assumption, because the synchronizer absorbs them. The bench drives every input 1.5 ns after a rising edge, which falls inside the 2.5 ns high phase. It releases reset 1 ns after a falling edge. Its randomized phase therefore varies the controls freely while staying inside these conditions.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  // Synchronized control word: power-down request and run (not stopped) request.
  typedef struct packed {
    logic pd;
    logic run;
  } ckg_ctl_t;

  // State the synchronizer holds during reset: stopped and powered down.
  localparam ckg_ctl_t CTL_RESET = '{pd: 1'b1, run: 1'b0};

  // A lane obeys the stop request unless it is fixed free, or selectable
  // with the select input at 0.
  function automatic logic is_stoppable(input logic fixed_free,
                                        input logic selectable,
                                        input logic sel_stop);
    return !fixed_free && (!selectable || sel_stop);
  endfunction

  // Whether a lane may pass its next pulse.
  function automatic logic run_wanted(input logic     stoppable,
                                      input logic     enable,
                                      input ckg_ctl_t ctl);
    return !ctl.pd && enable && (ctl.run || !stoppable);
  endfunction

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {NS{RST_VAL}};
    else        pipe <= {pipe[NS-2:0], d};
  end

  assign q = pipe[NS-1];
endmodule

// File: rtl/ckg_gate_cell.sv
module ckg_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic en_q,
  output logic clk_out
);
  // Latch open only during the low phase: the enable can never change
  // while a pulse is in progress.
  always_latch begin
    if (!rst_n)   en_q = 1'b0;
    else if (!clk) en_q = want;
  end

  assign clk_out = clk & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import ckg_pkg::*;
#(
  parameter int           N           = 4,
  parameter int           SYNC_STAGES = 2,
  parameter logic [N-1:0] FREE_MASK   = N'(1) << (N-1),
  parameter logic [N-1:0] SEL_MASK    = N'(1) << (N-2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_n,
  input  logic         pwr_down,
  input  logic         sel_stoppable,
  input  logic [N-1:0] out_en,
  output logic [N-1:0] clk_out
);
  localparam int CW = $bits(ckg_ctl_t);

  ckg_ctl_t ctl_raw;
  ckg_ctl_t ctl_sync;
  logic     run_sync;
  logic     pd_sync;

  logic [N-1:0] lane_stoppable;
  logic [N-1:0] lane_want;
  logic [N-1:0] lane_en;

  assign ctl_raw = '{pd: pwr_down, run: stop_n};

  ckg_sync #(
    .W      (CW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_RESET)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_sync)
  );

  assign run_sync = ctl_sync.run;
  assign pd_sync  = ctl_sync.pd;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign lane_stoppable[i] = is_stoppable(FREE_MASK[i], SEL_MASK[i], sel_stoppable);
    assign lane_want[i]      = run_wanted(lane_stoppable[i], out_en[i], ctl_sync);

    ckg_gate_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (lane_want[i]),
      .en_q   (lane_en[i]),
      .clk_out(clk_out[i])
    );
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] out_en,
  input logic [N-1:0] lane_stoppable,
  input logic [N-1:0] lane_en,
  input logic         pd_sync,
  input logic         run_sync
);

  // R8: synchronized power-down leaves no lane enabled for the coming pulse.
  p_pd_all_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_sync |-> (lane_en == '0))
    else $error("R8: lane enabled during power-down");

  // R4: synchronized stop leaves every stoppable lane off.
  p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_sync |-> ((lane_en & lane_stoppable) == '0))
    else $error("R4: stoppable lane running while stopped");

  // R7: a disabled lane is never latched on.
  p_mask_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_en & ~out_en) == '0))
    else $error("R7: disabled lane latched on");

  // R5 and R6: non-stoppable enabled lanes run whenever power-down is off.
  p_free_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_sync |-> ((~lane_stoppable & out_en & ~lane_en) == '0))
    else $error("R5: free lane was gated");

  // R3: the lane latches move only while the source clock is low.
  always @(lane_en) begin
    if (rst_n) begin
      a_update_low_r3: assert (!clk)
        else $error("R3: lane enable changed during high phase");
    end
  end

endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_en        (out_en),
  .lane_stoppable(lane_stoppable),
  .lane_en       (lane_en),
  .pd_sync       (pd_sync),
  .run_sync      (run_sync)
);

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
  localparam int N         = 4;
  localparam int S         = 2;
  localparam int FREE_LANE = 3;
  localparam int SEL_LANE  = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_r = 1'b1;
  logic         pd_r = 1'b0;
  logic         sel_r = 1'b1;
  logic [N-1:0] en_r = '1;
  logic [N-1:0] clk_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  clk_stop_gate #(.N(N), .SYNC_STAGES(S)) i_clk_stop_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_n       (stop_r),
    .pwr_down     (pd_r),
    .sel_stoppable(sel_r),
    .out_en       (en_r),
    .clk_out      (clk_out)
  );

  // Reference model: request samples delayed by S rising edges.
  bit [1:0]     hist[$];
  logic [N-1:0] exp_hi = '0;

  always @(posedge clk) begin
    bit [1:0] cur;
    bit       free;
    if (!rst_n) begin
      hist.delete();
      repeat (S) hist.push_back(2'b10);   // {pd, run}: powered down, stopped
      exp_hi = '0;
    end else begin
      hist.push_back({pd_r, stop_r});
      cur = hist.pop_front();
      for (int i = 0; i < N; i++) begin
        free      = (i == FREE_LANE) || (i == SEL_LANE && !sel_r);
        exp_hi[i] = !cur[1] && en_r[i] && (cur[0] || free);
      end
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clk_out=%b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // Early and late in each high phase: pulses must be whole.
  always @(posedge clk) begin
    #0.5 chk(clk_out, exp_hi, tag);
    #1.7 chk(clk_out, exp_hi, (tag == "R3") ? "R3" : tag);
  end

  // Low phase: every lane low.
  always @(negedge clk) begin
    #1 chk(clk_out, '0, "R2");
  end

  task automatic drive(input bit s, input bit p, input bit sel,
                       input logic [N-1:0] en, input int cycles);
    @(posedge clk);
    #1.5;
    stop_r = s; pd_r = p; sel_r = sel; en_r = en;
    repeat (cycles - 1) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL R1: watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset hold and release latency
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);

    // R4: stop and restart latency, selectable lane stoppable
    tag = "R4";
    drive(1'b0, 1'b0, 1'b1, 4'hF, 8);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 8);
    drive(1'b0, 1'b0, 1'b1, 4'hF, 1);   // one-cycle stop pulse
    drive(1'b1, 1'b0, 1'b1, 4'hF, 6);

    // R5: fixed free lane untouched by a long stop
    tag = "R5";
    drive(1'b0, 1'b0, 1'b1, 4'hF, 10);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 5);

    // R6: selectable lane as free-running, then switched while stopped
    tag = "R6";
    drive(1'b0, 1'b0, 1'b0, 4'hF, 6);
    drive(1'b0, 1'b0, 1'b1, 4'hF, 4);
    drive(1'b0, 1'b0, 1'b0, 4'hF, 4);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 4);

    // R7: enable patterns
    tag = "R7";
    drive(1'b1, 1'b0, 1'b1, 4'b0101, 4);
    drive(1'b1, 1'b0, 1'b1, 4'b1010, 4);
    drive(1'b1, 1'b0, 1'b1, 4'b0000, 4);
    drive(1'b0, 1'b0, 1'b0, 4'b0111, 4);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 4);

    // R8: power-down beats free lanes and enables
    tag = "R8";
    drive(1'b1, 1'b1, 1'b0, 4'hF, 6);
    drive(1'b0, 1'b1, 1'b0, 4'hF, 4);
    drive(1'b0, 1'b0, 1'b0, 4'hF, 4);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 5);

    // R3: random control changes inside high phases
    tag = "R3";
    for (int k = 0; k < 80; k++) begin
      logic [31:0] v;
      v = $urandom;
      drive(v[0] | v[1], v[2] & v[3] & v[4], v[5], v[9:6], 1);
    end
    drive(1'b1, 1'b0, 1'b1, 4'hF, 6);

    finish_run();
  end
endmodule